// File: doc/BRIEF.md
# XNOR-Feedback Sequence Counter

This block is a two-tap linear feedback shift register. It advances through a fixed pseudo-random order of states and can stand in for a binary counter wherever the count order does not matter: FIFO pointers, sequencers, or test pattern sources. Each step needs one flop per bit and one XNOR gate, so there is no carry chain. The feedback bit is the XNOR of two tap bits. Because of this the all-zero word is a legal member of the sequence and serves as the reset value. The all-ones word is the only state the sequence cannot leave on its own.

A parallel load port can place any value in the register, including the all-ones word. A small controller tracks whether that forbidden word is held. It has two states:
- `ST_RUN`: the register holds a sequence member.
- `ST_STUCK`: the register holds all ones.

The controller moves between them as follows:
- RUN->STUCK: a load of all ones.
- STUCK->RUN: a load of any other value, or an advance, which clears the register to zero.
- Reset returns the controller to RUN.
- Hold keeps the controller in its current state.

For each cycle the controller picks one action for the register: reset, load, step, clear or hold. The upper tap must be the most significant bit.

Top module: `lfsr_seq_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `state_q` becomes all zeros and `lockup` becomes low after that edge. Reset wins over `ld_en` and `adv_en`.
- R2: With `adv_en` high, `ld_en` low and no lockup, the next state is the current state shifted left by one bit. Bit 0 receives the XNOR of bit `TAP_HI` (default 14) and bit `TAP_LO` (default 0).
- R3: With `adv_en` and `ld_en` both low, `state_q` and `lockup` keep their values.
- R4: With `ld_en` high, the next state equals `ld_val`.
- R5: When `ld_en` and `adv_en` are both high, the load takes place and no step occurs.
- R6: `lockup` is high exactly when `state_q` is all ones.
- R7: An advance while `lockup` is high sets `state_q` to all zeros and clears `lockup`.
- R8: With the default 15-bit configuration, starting from reset, the state first returns to zero after exactly 32767 advances. It never shows all ones along the way, so every one of those 32767 states is distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance one step |
| ld_en | input | 1 | Parallel load strobe |
| ld_val | input | WIDTH | Value to load |
| state_q | output | WIDTH | Current register state |
| lockup | output | 1 | High while the state is all ones |

## Verification
The all-ones state cannot be reached by advancing, because a maximal sequence never visits it. The only way in is the load port, so the bench loads all ones on purpose and then checks recovery both by an advance and by a later load. The second hard case is the claim of no repetition. Because every state has exactly one successor, the first return to zero landing on step 32767 proves that the states before it were all distinct. The bench therefore runs the full period, compares every step against a model, and records every zero or all-ones word seen along the way.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STUCK = 1'b1
    } lfsr_mode_e;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_RESET = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_STEP  = 3'd3,
        ACT_CLEAR = 3'd4
    } lfsr_act_e;

endpackage

// File: rtl/lfsr_fb_net.sv
module lfsr_fb_net #(
    parameter int WIDTH  = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] nxt,
    output logic             ld_ones
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic fb_bit;

    assign fb_bit = ~(cur[TAP_HI] ^ cur[TAP_LO]);

    generate
        if (WIDTH > 1) begin : g_wide
            assign nxt = {cur[WIDTH-2:0], fb_bit};
        end else begin : g_one
            assign nxt = fb_bit;
        end
    endgenerate

    assign ld_ones = (ld_val == ALL_ONES);

endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
    import lfsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv_en,
    input  logic      ld_en,
    input  logic      ld_ones,
    output lfsr_act_e act,
    output logic      lockup
);
    lfsr_mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= ST_RUN;
        else     mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        act    = ACT_HOLD;
        if (rst) begin
            act    = ACT_RESET;
            mode_d = ST_RUN;
        end else begin
            unique case (mode_q)
                ST_RUN: begin
                    if (ld_en) begin
                        act    = ACT_LOAD;
                        mode_d = ld_ones ? ST_STUCK : ST_RUN;
                    end else if (adv_en) begin
                        act = ACT_STEP;
                    end
                end
                ST_STUCK: begin
                    if (ld_en) begin
                        act    = ACT_LOAD;
                        mode_d = ld_ones ? ST_STUCK : ST_RUN;
                    end else if (adv_en) begin
                        act    = ACT_CLEAR;
                        mode_d = ST_RUN;
                    end
                end
                default: begin
                    act    = ACT_RESET;
                    mode_d = ST_RUN;
                end
            endcase
        end
    end

    assign lockup = (mode_q == ST_STUCK);

    // R7
    stuck_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == ST_STUCK && adv_en && !ld_en) |=> (mode_q == ST_RUN));

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && adv_en) |-> (act == ACT_LOAD));

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_pkg::*;
#(
    parameter int WIDTH = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  lfsr_act_e        act,
    input  logic [WIDTH-1:0] step_val,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] state_q
);
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: state_q <= '0;
            ACT_CLEAR: state_q <= '0;
            ACT_LOAD:  state_q <= ld_val;
            ACT_STEP:  state_q <= step_val;
            default:   state_q <= state_q;
        endcase
    end

    // R1
    rst_zero_chk: assert property (@(posedge clk)
        rst |=> (state_q == '0));

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (state_q == $past(ld_val)));

endmodule

// File: rtl/lfsr_seq_counter.sv
module lfsr_seq_counter
    import lfsr_pkg::*;
#(
    parameter int WIDTH  = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] state_q,
    output logic             lockup
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] step_val;
    logic             ld_ones;
    lfsr_act_e        act;

    lfsr_fb_net #(.WIDTH(WIDTH), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_fb (
        .cur(state_q), .ld_val(ld_val), .nxt(step_val), .ld_ones(ld_ones)
    );

    lfsr_ctrl u_ctrl (
        .clk(clk), .rst(rst), .adv_en(adv_en), .ld_en(ld_en),
        .ld_ones(ld_ones), .act(act), .lockup(lockup)
    );

    lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk(clk), .rst(rst), .act(act), .step_val(step_val),
        .ld_val(ld_val), .state_q(state_q)
    );

    // R6
    lockup_match_chk: assert property (@(posedge clk) disable iff (rst)
        lockup == (state_q == ALL_ONES));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_en && !ld_en) |=> ($stable(state_q) && $stable(lockup)));

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !ld_en && !lockup) |=>
            (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !ld_en && lockup) |=> (state_q == '0 && !lockup));

endmodule

// File: tb/lfsr_seq_counter_test.sv
module lfsr_seq_counter_test;
    localparam int W = 15;
    localparam int PERIOD = (1 << W) - 1;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         adv_en = 1'b0;
    logic         ld_en = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic [W-1:0] state_q;
    logic         lockup;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lfsr_seq_counter uut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .ld_en(ld_en),
        .ld_val(ld_val), .state_q(state_q), .lockup(lockup)
    );

    function automatic logic [W-1:0] model_step(input logic [W-1:0] s);
        return {s[W-2:0], ~(s[W-1] ^ s[0])};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; adv_en = 1'b0; ld_en = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_load(input logic [W-1:0] v, input logic with_adv);
        @(negedge clk); ld_en = 1'b1; ld_val = v; adv_en = with_adv;
        @(negedge clk); ld_en = 1'b0; adv_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", state_q, '0);
        chk("R1 lockup", W'(lockup), '0);
    endtask

    task automatic t_reset_wins();
        @(negedge clk); rst = 1'b1; ld_en = 1'b1; ld_val = ONES; adv_en = 1'b1;
        @(negedge clk); rst = 1'b0; ld_en = 1'b0; adv_en = 1'b0;
        chk("R1 reset over load", state_q, '0);
        chk("R1 reset lockup", W'(lockup), '0);
    endtask

    task automatic t_hold();
        do_load(15'h1234, 1'b0);
        chk("R4 load", state_q, 15'h1234);
        repeat (3) @(negedge clk);
        chk("R3 hold", state_q, 15'h1234);
        chk("R3 hold lockup", W'(lockup), '0);
    endtask

    task automatic t_step_patterns();
        logic [W-1:0] exp;
        do_load(15'h4001, 1'b0);
        exp = 15'h4001;
        adv_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            exp = model_step(exp);
            chk("R2 step", state_q, exp);
        end
        adv_en = 1'b0;
    endtask

    task automatic t_load_priority();
        do_load(15'h0abc, 1'b1);
        chk("R5 load over advance", state_q, 15'h0abc);
    endtask

    task automatic t_lockup();
        do_load(ONES, 1'b0);
        chk("R6 lockup high", W'(lockup), W'(1));
        chk("R4 ones loaded", state_q, ONES);
        repeat (2) @(negedge clk);
        chk("R3 stuck hold", state_q, ONES);
        @(negedge clk); adv_en = 1'b1;
        @(negedge clk); adv_en = 1'b0;
        chk("R7 clear", state_q, '0);
        chk("R7 lockup low", W'(lockup), '0);
        do_load(ONES, 1'b0);
        do_load(15'h0005, 1'b0);
        chk("R6 lockup after reload", W'(lockup), '0);
        chk("R4 reload", state_q, 15'h0005);
    endtask

    task automatic t_full_period();
        logic [W-1:0] exp;
        int ones_seen;
        int early_zero;
        ones_seen = 0;
        early_zero = 0;
        do_reset();
        exp = '0;
        adv_en = 1'b1;
        for (int i = 1; i <= PERIOD; i++) begin
            @(negedge clk);
            exp = model_step(exp);
            chk("R2 sequence", state_q, exp);
            if (state_q == ONES || lockup) ones_seen++;
            if (state_q == '0 && i != PERIOD) early_zero++;
        end
        adv_en = 1'b0;
        chk("R8 back to zero", state_q, '0);
        chk("R8 no all-ones", W'(ones_seen), '0);
        chk("R8 no early zero", W'(early_zero), '0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_step_patterns();
        t_load_priority();
        t_lockup();
        t_reset_wins();
        t_full_period();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule